// File: doc/BRIEF.md
# Translation Lookaside Buffer with Flush and Page Invalidate

This block keeps recently used translations from virtual page numbers to physical page numbers, so that most memory accesses need no table walk. Pages are 4 KB: the upper 20 bits of a 32-bit virtual address form the page number and the low 12 bits pass straight into the physical address. Each entry holds a physical page number together with a user-access bit and a writable bit. A lookup is answered one cycle after it is presented. The answer is either a hit carrying the physical address and a protection verdict, or a miss.

On a miss the block raises a walk request for the missing page. The external walker returns the result on its own fill port. A successful result is installed with no software involvement. A faulting result installs nothing and is passed back to the requester as a walk fault. Writing the directory base register flushes every entry. A page-invalidate command removes only the entry for the page of the given address. The store is fully associative. A fill goes to the lowest-numbered free entry if one exists; otherwise it evicts the entry named by a round-robin pointer.

Top module: `tlb_cache`

## Requirements
- R1: On a hit, resp_pa_o equals the stored physical page number in bits 31:12 and lkp_va_i[11:0] in bits 11:0. On a miss, resp_pa_o is zero.
- R2: resp_valid_o is high exactly in the cycle after a cycle with lkp_valid_i high. The lookup sees the entries as they were before any update made in its own cycle.
- R3: resp_hit_o is high only if a valid entry's page number equals lkp_va_i[31:12].
- R4: A lookup that misses raises walk_req_o in its response cycle, with walk_vpn_o set to the missing page number. Otherwise walk_req_o is low and walk_vpn_o is zero.
- R5: A walk_done_i with walk_fault_i low installs walk_vpn_i → walk_ppn_i along with walk_user_i and walk_wr_i. A walk_done_i with walk_fault_i high installs nothing and drives walk_fault_o high one cycle later.
- R6: A base_wr_i cycle invalidates every entry.
- R7: On a hit, resp_fault_o is high when the user bit is 0 and lkp_user_i is 1. It is also high when lkp_write_i is 1, the writable bit is 0, and either lkp_user_i or wp_en_i is 1.
- R8: inval_i removes the entry whose page number equals inval_va_i[31:12], if there is one, and leaves all other entries untouched.
- R9: A fill for a page that is not present goes to the lowest-indexed invalid entry. If every entry is valid, it goes to the entry at the round-robin pointer. The pointer starts at 0 after reset and advances by one, wrapping, only on such evictions.
- R10: A fill in the same cycle as base_wr_i is discarded. A fill in the same cycle as inval_i with the same page number is discarded.
- R11: A fill for a page already present overwrites that entry, so a page never occupies two entries.
- R12: After reset all entries are invalid and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_va_i | input | 32 | Lookup virtual address |
| lkp_user_i | input | 1 | Access is made from user mode |
| lkp_write_i | input | 1 | Access is a write |
| wp_en_i | input | 1 | Supervisor writes honour the writable bit |
| resp_valid_o | output | 1 | Lookup response valid |
| resp_hit_o | output | 1 | Lookup hit |
| resp_fault_o | output | 1 | Protection fault on a hit |
| resp_pa_o | output | 32 | Physical address on a hit |
| walk_req_o | output | 1 | Walk request after a miss |
| walk_vpn_o | output | 20 | Page number to walk |
| walk_done_i | input | 1 | Walker result valid |
| walk_fault_i | input | 1 | Walker result is a fault |
| walk_vpn_i | input | 20 | Walked virtual page number |
| walk_ppn_i | input | 20 | Resulting physical page number |
| walk_user_i | input | 1 | Resulting user bit |
| walk_wr_i | input | 1 | Resulting writable bit |
| walk_fault_o | output | 1 | Walk fault passed to the requester |
| base_wr_i | input | 1 | Directory base written: flush all |
| inval_i | input | 1 | Invalidate one page |
| inval_va_i | input | 32 | Address whose page is invalidated |

## Verification
Lookups are run against an empty store, against a single fill, and against a full store with two further fills. The last of these separates lowest-free placement from round-robin eviction and tracks the pointer across an invalidate-then-refill. Protection is tried with every combination of user, write and write-protect against entries that differ in the user and writable bits. This tells the user rule apart from the write rule. Fills are placed in the same cycle as a flush, a matching invalidate and a non-matching invalidate, which shows which update wins. A repeated fill with a new frame shows that the entry is replaced rather than duplicated. A faulting walk shows that nothing is allocated.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  function automatic logic prot_fault(input logic usr_ok, input logic wr_ok,
                                      input logic user, input logic write,
                                      input logic wp);
    return (!usr_ok && user) || (write && !wr_ok && (user || wp));
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N = 16,
  parameter int W = 20
) (
  input  logic [N-1:0]        valid_i,
  input  logic [N-1:0][W-1:0] tag_i,
  input  logic [W-1:0]        key_i,
  output logic [N-1:0]        hit_o
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_o[i] = valid_i[i] && (tag_i[i] == key_i);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  valid_i,
  input  logic [IW-1:0] rr_i,
  output logic [IW-1:0] idx_o,
  output logic          evict_o
);
  always_comb begin
    idx_o   = rr_i;
    evict_o = 1'b1;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        idx_o   = IW'(i);
        evict_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lkp_valid_i,
  input  logic [VA_W-1:0]     lkp_va_i,
  input  logic                lkp_user_i,
  input  logic                lkp_write_i,
  input  logic                wp_en_i,
  output logic                resp_valid_o,
  output logic                resp_hit_o,
  output logic                resp_fault_o,
  output logic [PA_W-1:0]     resp_pa_o,
  output logic                walk_req_o,
  output logic [VA_W-OFF_W-1:0] walk_vpn_o,
  input  logic                walk_done_i,
  input  logic                walk_fault_i,
  input  logic [VA_W-OFF_W-1:0] walk_vpn_i,
  input  logic [PA_W-OFF_W-1:0] walk_ppn_i,
  input  logic                walk_user_i,
  input  logic                walk_wr_i,
  output logic                walk_fault_o,
  input  logic                base_wr_i,
  input  logic                inval_i,
  input  logic [VA_W-1:0]     inval_va_i
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             vld_q, usr_q, wr_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [IDX_W-1:0]               rr_q;

  logic [ENTRIES-1:0] lkp_match, fill_match, inv_match;
  logic [VPN_W-1:0]   lkp_vpn, inv_vpn;
  assign lkp_vpn = lkp_va_i[VA_W-1:OFF_W];
  assign inv_vpn = inval_va_i[VA_W-1:OFF_W];

  tlb_match #(.N(ENTRIES), .W(VPN_W)) u_lkp_match (
    .valid_i(vld_q), .tag_i(vpn_q), .key_i(lkp_vpn), .hit_o(lkp_match));
  tlb_match #(.N(ENTRIES), .W(VPN_W)) u_fill_match (
    .valid_i(vld_q), .tag_i(vpn_q), .key_i(walk_vpn_i), .hit_o(fill_match));
  tlb_match #(.N(ENTRIES), .W(VPN_W)) u_inv_match (
    .valid_i(vld_q), .tag_i(vpn_q), .key_i(inv_vpn), .hit_o(inv_match));

  logic [IDX_W-1:0] vic_idx;
  logic             vic_evict;
  tlb_victim #(.N(ENTRIES), .IW(IDX_W)) u_victim (
    .valid_i(vld_q), .rr_i(rr_q), .idx_o(vic_idx), .evict_o(vic_evict));

  // one-hot read of the lookup hit
  logic             lkp_hit, hit_usr, hit_wr;
  logic [PPN_W-1:0] hit_ppn;
  always_comb begin
    hit_ppn = '0;
    hit_usr = 1'b0;
    hit_wr  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkp_match[i]) begin
        hit_ppn = hit_ppn | ppn_q[i];
        hit_usr = hit_usr | usr_q[i];
        hit_wr  = hit_wr  | wr_q[i];
      end
    end
  end
  assign lkp_hit = |lkp_match;

  // fill target: existing entry, else free/round-robin victim
  logic             fill_ok, fill_present, fill_evict;
  logic [IDX_W-1:0] fill_idx, fill_enc;
  always_comb begin
    fill_enc = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (fill_match[i]) fill_enc = IDX_W'(i);
  end
  assign fill_present = |fill_match;
  assign fill_idx     = fill_present ? fill_enc : vic_idx;
  assign fill_evict   = !fill_present && vic_evict;
  assign fill_ok      = walk_done_i && !walk_fault_i && !base_wr_i &&
                        !(inval_i && (inv_vpn == walk_vpn_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      usr_q <= '0;
      wr_q  <= '0;
      vpn_q <= '0;
      ppn_q <= '0;
      rr_q  <= '0;
    end else begin
      if (base_wr_i)    vld_q <= '0;
      else if (inval_i) vld_q <= vld_q & ~inv_match;
      if (fill_ok) begin
        vld_q[fill_idx] <= 1'b1;
        vpn_q[fill_idx] <= walk_vpn_i;
        ppn_q[fill_idx] <= walk_ppn_i;
        usr_q[fill_idx] <= walk_user_i;
        wr_q[fill_idx]  <= walk_wr_i;
        if (fill_evict)
          rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_fault_o <= 1'b0;
      resp_pa_o    <= '0;
      walk_req_o   <= 1'b0;
      walk_vpn_o   <= '0;
      walk_fault_o <= 1'b0;
    end else begin
      resp_valid_o <= lkp_valid_i;
      resp_hit_o   <= lkp_valid_i && lkp_hit;
      resp_fault_o <= lkp_valid_i && lkp_hit &&
                      prot_fault(hit_usr, hit_wr, lkp_user_i, lkp_write_i, wp_en_i);
      resp_pa_o    <= (lkp_valid_i && lkp_hit) ? {hit_ppn, lkp_va_i[OFF_W-1:0]} : '0;
      walk_req_o   <= lkp_valid_i && !lkp_hit;
      walk_vpn_o   <= (lkp_valid_i && !lkp_hit) ? lkp_vpn : '0;
      walk_fault_o <= walk_done_i && walk_fault_i;
    end
  end

  // R2
  resp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |=> resp_valid_o);
  // R2
  no_spurious_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |=> !resp_valid_o);
  // R4
  walk_on_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_o |-> (resp_valid_o && !resp_hit_o));
  // R5
  fault_no_alloc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_done_i && walk_fault_i && !base_wr_i && !inval_i) |=> (vld_q == $past(vld_q)));
  // R6
  flush_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_wr_i |=> (vld_q == '0));
  // R7
  fault_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_fault_o |-> resp_hit_o);
  // R11
  unique_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fill_match));
endmodule

// File: tb/tb_tlb_cache.sv
module tb_tlb_cache;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        lv = 0, lu = 0, lw = 0, wp = 0;
  logic [31:0] lva = 0;
  logic        wdone = 0, wfault = 0, wu = 0, ww = 0, bw = 0, inv = 0;
  logic [19:0] wvpn = 0, wppn = 0;
  logic [31:0] iva = 0;
  logic        r_v, r_h, r_f, w_req, w_f;
  logic [31:0] r_pa;
  logic [19:0] w_vpn;

  tlb_cache dut (
    .clk_i(clk), .rst_ni(rst_n), .lkp_valid_i(lv), .lkp_va_i(lva), .lkp_user_i(lu),
    .lkp_write_i(lw), .wp_en_i(wp), .resp_valid_o(r_v), .resp_hit_o(r_h),
    .resp_fault_o(r_f), .resp_pa_o(r_pa), .walk_req_o(w_req), .walk_vpn_o(w_vpn),
    .walk_done_i(wdone), .walk_fault_i(wfault), .walk_vpn_i(wvpn), .walk_ppn_i(wppn),
    .walk_user_i(wu), .walk_wr_i(ww), .walk_fault_o(w_f), .base_wr_i(bw),
    .inval_i(inv), .inval_va_i(iva));

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state
  bit        mv[N];
  bit [19:0] mvpn[N], mppn[N];
  bit        mu[N], mw[N];
  int        rr = 0;
  bit        e_v, e_h, e_f, e_wreq, e_wf;
  bit [31:0] e_pa;
  bit [19:0] e_wvpn;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int find(bit [19:0] vpn);
    for (int i = 0; i < N; i++) if (mv[i] && mvpn[i] == vpn) return i;
    return -1;
  endfunction

  task automatic tick();
    int h, tgt, fr;
    bit ok;
    // lookup on pre-state
    h = find(lva[31:12]);
    e_v = lv; e_h = lv && h >= 0; e_f = 0; e_pa = 0; e_wreq = lv && h < 0; e_wvpn = 0;
    if (e_h) begin
      e_pa = {mppn[h], lva[11:0]};
      e_f  = (!mu[h] && lu) || (lw && !mw[h] && (lu || wp));
    end
    if (e_wreq) e_wvpn = lva[31:12];
    e_wf = wdone && wfault;
    // fill target on pre-state
    ok = wdone && !wfault && !bw && !(inv && iva[31:12] == wvpn);
    tgt = find(wvpn);
    fr = -1;
    if (tgt < 0) begin
      for (int i = N - 1; i >= 0; i--) if (!mv[i]) fr = i;
    end
    if (bw) foreach (mv[i]) mv[i] = 0;
    else if (inv) begin
      h = find(iva[31:12]);
      if (h >= 0) mv[h] = 0;
    end
    if (ok) begin
      if (tgt < 0) begin
        if (fr >= 0) tgt = fr;
        else begin tgt = rr; rr = (rr + 1) % N; end
      end
      mv[tgt] = 1; mvpn[tgt] = wvpn; mppn[tgt] = wppn; mu[tgt] = wu; mw[tgt] = ww;
    end
    @(posedge clk);
    #1;
    chk("R2", "resp_valid", r_v, e_v);
    chk("R3", "resp_hit", r_h, e_h);
    chk("R7", "resp_fault", r_f, e_f);
    chk("R1", "resp_pa", r_pa, e_pa);
    chk("R4", "walk_req", w_req, e_wreq);
    chk("R4", "walk_vpn", w_vpn, e_wvpn);
    chk("R5", "walk_fault", w_f, e_wf);
    lv = 0; lu = 0; lw = 0; wdone = 0; wfault = 0; bw = 0; inv = 0;
  endtask

  task automatic look(bit [31:0] va, bit u = 0, bit w = 0);
    lv = 1; lva = va; lu = u; lw = w; tick();
  endtask

  task automatic fill(bit [19:0] vpn, bit [19:0] ppn, bit u = 1, bit w = 1, bit f = 0);
    wdone = 1; wvpn = vpn; wppn = ppn; wu = u; ww = w; wfault = f;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    foreach (mv[i]) mv[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    // R12 reset state
    chk("R12", "resp_valid", r_v, 0);
    chk("R12", "walk_req", w_req, 0);
    chk("R12", "walk_fault", w_f, 0);
    chk("R12", "resp_pa", r_pa, 0);
    rst_n = 1;
    #1;
    // R4 miss on empty store, R5 fill then hit, R1 offset
    look(32'h1234_5678);
    fill(20'h12345, 20'hABCDE); tick();
    look(32'h1234_5FFF);
    look(32'h1234_6000);
    // R5 faulting walk does not allocate
    fill(20'h77777, 20'h11111, 1, 1, 1); tick();
    look(32'h7777_7000);
    // R7 protection combinations
    fill(20'h00010, 20'h00A10, 0, 1); tick();
    fill(20'h00020, 20'h00A20, 1, 0); tick();
    for (int k = 0; k < 8; k++) begin
      wp = k[2];
      look(32'h0001_0004, k[0], k[1]);
      look(32'h0002_0008, k[0], k[1]);
    end
    wp = 0;
    // R11 refill with new frame overwrites
    fill(20'h12345, 20'h55555); tick();
    look(32'h1234_5010);
    // R6 flush
    bw = 1; tick();
    look(32'h1234_5010);
    look(32'h0001_0000);
    // R9 fill all slots, then round-robin eviction
    for (int i = 0; i < N; i++) begin fill(20'h00100 + i, 20'h08000 + i); tick(); end
    fill(20'h00200, 20'h09000); tick();
    fill(20'h00201, 20'h09001); tick();
    for (int i = 0; i < 4; i++) look({20'h00100 + 20'(i), 12'h0});
    look({20'h00200, 12'h0});
    // R8 invalidate one page, others remain
    inv = 1; iva = {20'h00105, 12'h123}; tick();
    look({20'h00105, 12'h0});
    look({20'h00106, 12'h0});
    look({20'h00104, 12'h0});
    // R9 free slot used first, pointer held
    fill(20'h00300, 20'h0A000); tick();
    fill(20'h00301, 20'h0A001); tick();
    look({20'h00300, 12'h0});
    look({20'h00102, 12'h0});
    look({20'h00103, 12'h0});
    // R10 flush beats fill
    fill(20'h00400, 20'h0B000); bw = 1; tick();
    look({20'h00400, 12'h0});
    // R10 matching invalidate discards fill
    fill(20'h00401, 20'h0B001); inv = 1; iva = {20'h00401, 12'h0}; tick();
    look({20'h00401, 12'h0});
    // R10 non-matching invalidate lets fill in
    fill(20'h00402, 20'h0B002); tick();
    fill(20'h00403, 20'h0B003); inv = 1; iva = {20'h00402, 12'h0}; tick();
    look({20'h00402, 12'h0});
    look({20'h00403, 12'hFED});
    // R2 lookup sees pre-update state in a flush cycle
    lv = 1; lva = {20'h00403, 12'h001}; bw = 1; tick();
    look({20'h00403, 12'h001});
    tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule